// File: doc/BRIEF.md
# Cascaded Three-Level Interrupt Controller

This block gathers interrupt requests from peripherals into one CPU interrupt output across three stages. Seven slot request lines feed a slot flag register whose bits are active low: a bit reads 0 while its slot interrupt is pending. A slot enable register qualifies those flags. Their combined summary, together with six other device request lines, feeds a secondary flag register whose bits are active high, with its own enable register. The secondary summary and five primary device lines form the six CPU-level source lines. Any change on these lines is captured in a device-line register. The change also sets a sticky CPU interrupt latch, and only software can clear that latch.

Software reaches every register through a byte-wide port with a 3-bit address. Writes take effect at the clock edge where `wr_en` is high. Reads are combinational from `addr`. Request inputs are level signals that are sampled every clock. Each stage acts only when a level changes, so a level that stays high produces no further event. The CPU stage acts only after software has set the interrupt-emulation mode bit.

Top module: `irq_cascade`

## Requirements
- R1: After reset the registers read as follows: address 0 (slot flags) reads 0x7F, address 1 (slot enables) reads 0x00, address 2 (secondary flags) reads 0x00, address 3 (secondary enables) reads 0x00, and address 4 (control) reads 0x00. `cpu_irq` is 0. Address 0 bit 7 and address 1 and 3 bit 7 always read 0.
- R2: A write to an enable register (address 1 or 3) with data bit 7 set ORs data bits 6:0 into the enables. With data bit 7 clear, every enable bit whose data bit is 1 is cleared and the other bits are kept.
- R3: A rising edge on `slot_req[i]` drives slot flag bit i to 0 (pending) after that clock. A falling edge drives it back to 1.
- R4: Writing address 0 with data bit 0 set returns slot flag bit 0 (the vertical-blank slot) to 1. Writes have no effect on slot flag bits 6:1.
- R5: Slot summary = OR over bits 6:0 of (NOT slot flag AND slot enable). Each change of this summary sets or clears secondary flag bit 6 to match its new value one clock later.
- R6: A rising edge on `sec_req[k]` (k = 0..5) sets secondary flag bit k, and a falling edge clears it. Writing 1s to address 2 clears the matching flag bits 6:0. Data bit 7 of that write is ignored. When a source edge and a write hit the same bit in the same cycle, the edge wins.
- R7: Address 2 bit 7 reads the secondary summary: OR over bits 6:0 of (secondary flag AND secondary enable).
- R8: Control register (address 4) bit 6 is the emulation mode bit. A write with data bit 6 = 1 sets it, and nothing but reset clears it. The six CPU source lines are: bit 1 = secondary summary, bit 0 = `cpu_req[0]`, and bits 5:2 = `cpu_req[4:1]`. While the mode bit is set, any change on these lines copies them into the device-line register and sets the CPU flag, which drives `cpu_irq`. While the mode bit is clear, a change has no effect.
- R9: A write to address 4 with data bit 7 = 1 clears the CPU flag. Otherwise the flag holds once set. If a source change and the clear occur in the same cycle, the flag stays set.
- R10: Address 4 reads {CPU flag, mode bit, device lines[5:0]}. Writes cannot change bits 7 and 5:0 directly. Any other address reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slot_req | input | 7 | Slot interrupt request levels, active high |
| sec_req | input | 6 | Device request levels for secondary flag bits 5:0 |
| cpu_req | input | 5 | Primary device request levels for CPU source bits 0 and 5:2 |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data for `addr` |
| cpu_irq | output | 1 | CPU interrupt request, high while the CPU flag is set |

## Verification
The embedded properties check every cycle that enable writes set or clear the selected bits. They also check that a source edge marks its flag pending and that a flag with neither an edge nor a write holds its value. On the CPU latch they check that a change in emulation mode sets the latch and captures the lines, that the latch is sticky, that software clears it, and that the mode bit never drops. A rise of the secondary summary in mode must reach `cpu_irq`. The bench scenarios are needed for the rest. Those cover the end-to-end latency from a slot edge to the CPU output, the rule that writes leave slot bits other than vertical blank unchanged, the ignored bit 7 of the secondary flag write, the fact that a change before mode is set is lost, and the same-cycle contest between a clear and a new event.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;
  localparam int unsigned FLAG_W  = 7;
  localparam int unsigned LINE_W  = 6;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;

  localparam logic [ADDR_W-1:0] A_SLOT_FLAG = 3'd0;
  localparam logic [ADDR_W-1:0] A_SLOT_EN   = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEC_FLAG  = 3'd2;
  localparam logic [ADDR_W-1:0] A_SEC_EN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_CTRL      = 3'd4;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned W          = 7,
  parameter bit          ACTIVE_LOW = 1'b0,
  parameter logic [W-1:0] CLR_MASK  = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         flag_we,
  input  logic         en_we,
  input  logic [W:0]   wdata,
  output logic [W-1:0] flag_q,
  output logic [W-1:0] en_q,
  output logic         summary
);
  localparam logic [W-1:0] FLAG_RST = ACTIVE_LOW ? '1 : '0;

  logic [W-1:0] src_q;
  logic [W-1:0] pend;
  logic [W-1:0] pend_nxt;
  logic [W-1:0] rise;
  logic [W-1:0] fall;
  logic [W-1:0] wclr;
  logic [W-1:0] flag_d;
  logic [W-1:0] en_d;

  generate
    if (ACTIVE_LOW) begin : g_low
      assign pend   = ~flag_q;
      assign flag_d = ~pend_nxt;
    end else begin : g_high
      assign pend   = flag_q;
      assign flag_d = pend_nxt;
    end
  endgenerate

  always_comb begin
    rise     = src & ~src_q;
    fall     = ~src & src_q;
    wclr     = flag_we ? (wdata[W-1:0] & CLR_MASK) : '0;
    pend_nxt = (pend & ~(fall | wclr)) | rise;
    if (en_we) begin
      en_d = wdata[W] ? (en_q | wdata[W-1:0]) : (en_q & ~wdata[W-1:0]);
    end else begin
      en_d = en_q;
    end
    summary = |(pend & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      flag_q <= FLAG_RST;
      en_q   <= '0;
    end else begin
      src_q  <= src;
      flag_q <= flag_d;
      en_q   <= en_d;
    end
  end

  a_r2_enable_or: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && wdata[W]) |=> ((en_q & $past(wdata[W-1:0])) == $past(wdata[W-1:0])));

  a_r2_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (en_we && !wdata[W]) |=> ((en_q & $past(wdata[W-1:0])) == '0));

  a_r3_rise_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (|(src & ~src_q)) |=> ((pend & $past(src & ~src_q)) == $past(src & ~src_q)));

  a_r6_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_we && (src == src_q)) |=> $stable(flag_q));
endmodule

// File: rtl/irq_cpu_latch.sv
module irq_cpu_latch #(
  parameter int unsigned W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         ctrl_we,
  input  logic [1:0]   wdata_hi,
  output logic         irq_q,
  output logic         mode_q,
  output logic [W-1:0] lines_q
);
  logic [W-1:0] src_q;
  logic         chg;
  logic         irq_d;
  logic         mode_d;
  logic [W-1:0] lines_d;

  always_comb begin
    chg    = (src != src_q);
    mode_d = mode_q | (ctrl_we & wdata_hi[0]);
    if (mode_q && chg) begin
      irq_d   = 1'b1;
      lines_d = src;
    end else begin
      irq_d   = (ctrl_we && wdata_hi[1]) ? 1'b0 : irq_q;
      lines_d = lines_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      irq_q   <= 1'b0;
      mode_q  <= 1'b0;
      lines_q <= '0;
    end else begin
      src_q   <= src;
      irq_q   <= irq_d;
      mode_q  <= mode_d;
      lines_q <= lines_d;
    end
  end

  a_r8_change_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && (src != src_q)) |=> (irq_q && (lines_q == $past(src))));

  a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q |=> mode_q);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(ctrl_we && wdata_hi[1])) |=> irq_q);

  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && wdata_hi[1] && !(mode_q && (src != src_q))) |=> !irq_q);
endmodule

// File: rtl/irq_cascade.sv
module irq_cascade
  import irq_cascade_pkg::*;
#(
  parameter int unsigned VBL_BIT      = 0,
  parameter int unsigned SLOT_SUM_BIT = 6,
  parameter int unsigned CPU_SEC_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] slot_req,
  input  logic [FLAG_W-2:0] sec_req,
  input  logic [LINE_W-2:0] cpu_req,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              cpu_irq
);
  localparam logic [FLAG_W-1:0] VBL_MASK = FLAG_W'(1) << VBL_BIT;

  logic [1:0]        rst_sync;
  logic              rst_i_n;
  logic [FLAG_W-1:0] slot_flag;
  logic [FLAG_W-1:0] slot_en;
  logic              slot_sum;
  logic [FLAG_W-1:0] sec_src;
  logic [FLAG_W-1:0] sec_flag;
  logic [FLAG_W-1:0] sec_en;
  logic              sec_sum;
  logic [LINE_W-1:0] cpu_src;
  logic              cpu_flag;
  logic              cpu_mode;
  logic [LINE_W-1:0] dev_lines;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i_n = rst_sync[1];

  irq_flag_bank #(.W(FLAG_W), .ACTIVE_LOW(1'b1), .CLR_MASK(VBL_MASK)) i_slot (
    .clk(clk), .rst_n(rst_i_n), .src(slot_req),
    .flag_we(wr_en && addr == A_SLOT_FLAG), .en_we(wr_en && addr == A_SLOT_EN),
    .wdata(wr_data), .flag_q(slot_flag), .en_q(slot_en), .summary(slot_sum)
  );

  for (genvar i = 0; i < FLAG_W; i++) begin : g_sec_map
    if (i == SLOT_SUM_BIT) begin : g_sum
      assign sec_src[i] = slot_sum;
    end else begin : g_dev
      localparam int J = (i < SLOT_SUM_BIT) ? i : i - 1;
      assign sec_src[i] = sec_req[J];
    end
  end

  irq_flag_bank #(.W(FLAG_W), .ACTIVE_LOW(1'b0), .CLR_MASK('1)) i_sec (
    .clk(clk), .rst_n(rst_i_n), .src(sec_src),
    .flag_we(wr_en && addr == A_SEC_FLAG), .en_we(wr_en && addr == A_SEC_EN),
    .wdata(wr_data), .flag_q(sec_flag), .en_q(sec_en), .summary(sec_sum)
  );

  for (genvar i = 0; i < LINE_W; i++) begin : g_cpu_map
    if (i == CPU_SEC_BIT) begin : g_sum
      assign cpu_src[i] = sec_sum;
    end else begin : g_dev
      localparam int J = (i < CPU_SEC_BIT) ? i : i - 1;
      assign cpu_src[i] = cpu_req[J];
    end
  end

  irq_cpu_latch #(.W(LINE_W)) i_cpu (
    .clk(clk), .rst_n(rst_i_n), .src(cpu_src),
    .ctrl_we(wr_en && addr == A_CTRL), .wdata_hi(wr_data[7:6]),
    .irq_q(cpu_flag), .mode_q(cpu_mode), .lines_q(dev_lines)
  );

  always_comb begin
    case (addr)
      A_SLOT_FLAG: rd_data = {1'b0, slot_flag};
      A_SLOT_EN:   rd_data = {1'b0, slot_en};
      A_SEC_FLAG:  rd_data = {sec_sum, sec_flag};
      A_SEC_EN:    rd_data = {1'b0, sec_en};
      A_CTRL:      rd_data = {cpu_flag, cpu_mode, dev_lines};
      default:     rd_data = '0;
    endcase
  end

  assign cpu_irq = cpu_flag;

  a_r7_cascade_to_cpu: assert property (@(posedge clk) disable iff (!rst_i_n)
    ($rose(sec_sum) && cpu_mode) |=> cpu_irq);
endmodule

// File: tb/test_irq_cascade.sv
module test_irq_cascade;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] slot_req = '0;
  logic [5:0] sec_req = '0;
  logic [4:0] cpu_req = '0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       cpu_irq;

  int n_chk = 0;
  int n_fail = 0;
  string tag = "R1";

  irq_cascade i_irq_cascade (
    .clk(clk), .rst_n(rst_n), .slot_req(slot_req), .sec_req(sec_req),
    .cpu_req(cpu_req), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cpu_irq(cpu_irq)
  );

  always #4 clk = ~clk;

  // behavioural reference state
  bit [6:0] m_sf, m_se, m_qf, m_qe, p_slot, p_sec;
  bit [5:0] m_dev, p_cpu;
  bit       m_flag, m_mode;

  function automatic bit [7:0] m_read(input bit [2:0] a);
    case (a)
      0: return {1'b0, m_sf};
      1: return {1'b0, m_se};
      2: return {|(m_qf & m_qe), m_qf};
      3: return {1'b0, m_qe};
      4: return {m_flag, m_mode, m_dev};
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input string t, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", t, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sf = 7'h7F; m_se = 0; m_qf = 0; m_qe = 0; p_slot = 0; p_sec = 0;
      m_dev = 0; p_cpu = 0; m_flag = 0; m_mode = 0;
    end else begin
      bit ssum, qsum, chg;
      bit [6:0] qsrc;
      bit [5:0] csrc;
      ssum = |(~m_sf & m_se);
      qsum = |(m_qf & m_qe);
      qsrc = {ssum, sec_req};
      csrc = {cpu_req[4:1], qsum, cpu_req[0]};
      for (int i = 0; i < 7; i++) begin
        if (slot_req[i] && !p_slot[i]) m_sf[i] = 0;
        else if (!slot_req[i] && p_slot[i]) m_sf[i] = 1;
        else if (wr_en && addr == 0 && i == 0 && wr_data[0]) m_sf[i] = 1;
        if (qsrc[i] && !p_sec[i]) m_qf[i] = 1;
        else if (!qsrc[i] && p_sec[i]) m_qf[i] = 0;
        else if (wr_en && addr == 2 && wr_data[i]) m_qf[i] = 0;
      end
      if (wr_en && addr == 1) m_se = wr_data[7] ? (m_se | wr_data[6:0]) : (m_se & ~wr_data[6:0]);
      if (wr_en && addr == 3) m_qe = wr_data[7] ? (m_qe | wr_data[6:0]) : (m_qe & ~wr_data[6:0]);
      chg = (csrc != p_cpu);
      if (m_mode && chg) begin
        m_flag = 1; m_dev = csrc;
      end else if (wr_en && addr == 4 && wr_data[7]) begin
        m_flag = 0;
      end
      if (wr_en && addr == 4 && wr_data[6]) m_mode = 1;
      p_slot = slot_req; p_sec = qsrc; p_cpu = csrc;
    end
    #2;
    check({tag, " model rd_data"}, rd_data, m_read(addr));
    check({tag, " model cpu_irq"}, cpu_irq, m_flag);
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit [2:0] a, input bit [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input string t, input bit [2:0] a, input bit [7:0] exp);
    idle(3);
    addr = a;
    @(posedge clk);
    #2;
    check(t, rd_data, exp);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(4);
    // R1 reset state
    tag = "R1";
    rd("R1 slot flags", 0, 8'h7F);
    rd("R1 slot en", 1, 8'h00);
    rd("R1 sec flags", 2, 8'h00);
    rd("R1 sec en", 3, 8'h00);
    rd("R1 ctrl", 4, 8'h00);
    check("R1 cpu_irq", cpu_irq, 0);
    // R2 enable set/clear
    tag = "R2";
    wr(1, 8'h85); wr(1, 8'h83); wr(1, 8'h02);
    rd("R2 slot en", 1, 8'h05);
    wr(3, 8'hFF); wr(3, 8'h7E);
    rd("R2 sec en", 3, 8'h01);
    // R3 / R5 / R7 slot edge cascade
    tag = "R3";
    @(negedge clk); slot_req = 7'h04;
    rd("R3 slot pending", 0, 8'h7B);
    tag = "R5";
    rd("R5 all-slot flag set", 2, 8'h40);
    tag = "R7";
    wr(3, 8'hC0);
    rd("R7 summary bit", 2, 8'hC0);
    tag = "R3";
    @(negedge clk); slot_req = 7'h00;
    rd("R3 slot released", 0, 8'h7F);
    tag = "R5";
    rd("R5 all-slot flag cleared", 2, 8'h00);
    // R4 vertical-blank clear, other bits ignore writes
    tag = "R4";
    @(negedge clk); slot_req = 7'h01;
    rd("R4 vbl pending", 0, 8'h7E);
    wr(0, 8'h01);
    rd("R4 vbl cleared", 0, 8'h7F);
    @(negedge clk); slot_req = 7'h09;
    rd("R4 bit3 pending", 0, 8'h77);
    wr(0, 8'h08);
    rd("R4 bit3 ignores write", 0, 8'h77);
    @(negedge clk); slot_req = 7'h00;
    rd("R4 released", 0, 8'h7F);
    rd("R4 sec after", 2, 8'h00);
    // R6 secondary flags
    tag = "R6";
    @(negedge clk); sec_req = 6'h08;
    rd("R6 sec set", 2, 8'h08);
    wr(2, 8'h88);
    rd("R6 write clears", 2, 8'h00);
    @(negedge clk); sec_req = 6'h00;
    @(negedge clk); sec_req = 6'h08;
    rd("R6 sec set again", 2, 8'h08);
    wr(2, 8'h80);
    rd("R6 bit7 write ignored", 2, 8'h08);
    @(negedge clk); sec_req = 6'h00;
    rd("R6 fall clears", 2, 8'h00);
    // R8 mode gating
    tag = "R8";
    @(negedge clk); cpu_req = 5'h01;
    rd("R8 no mode no effect", 4, 8'h00);
    check("R8 irq low without mode", cpu_irq, 0);
    wr(4, 8'h40);
    rd("R8 mode set", 4, 8'h40);
    @(negedge clk); cpu_req = 5'h05;
    tag = "R10";
    rd("R10 ctrl read lines", 4, 8'hC9);
    check("R8 irq asserted", cpu_irq, 1);
    // R9 clear and stickiness
    tag = "R9";
    wr(4, 8'h80);
    rd("R9 cleared", 4, 8'h49);
    check("R9 irq released", cpu_irq, 0);
    wr(4, 8'h80);
    wr(4, 8'h00);
    rd("R8 mode kept", 4, 8'h49);
    @(negedge clk); cpu_req = 5'h00;
    rd("R9 new change sets", 4, 8'hC0);
    idle(5);
    check("R9 sticky", cpu_irq, 1);
    wr(4, 8'h80);
    // R7 full cascade slot -> sec -> cpu
    tag = "R7";
    @(negedge clk); slot_req = 7'h04;
    rd("R7 cascade to ctrl", 4, 8'hC2);
    wr(4, 8'h80);
    rd("R7 cleared", 4, 8'h42);
    @(negedge clk); slot_req = 7'h00;
    rd("R7 fall sets", 4, 8'hC0);
    wr(4, 8'h80);
    // R9 set wins over same-cycle clear
    tag = "R9";
    @(negedge clk);
    wr_en = 1; addr = 4; wr_data = 8'h80; cpu_req = 5'h01;
    @(negedge clk);
    wr_en = 0;
    rd("R9 set beats clear", 4, 8'hC1);
    tag = "R10";
    rd("R10 unused address", 7, 8'h00);
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule